// File: doc/BRIEF.md
# Pulse-pause frame demodulator

This block turns a single digital line, high while the reader's carrier is on and low during a pause, into received frames. Every bit is carried by the spacing between the starts of two successive pauses, measured on a free-running tick counter that advances once per clock. A start command puts the block into a search for the start-of-frame pause. Each later pause closes one bit: a long spacing decodes as 1 and a short one as 0. Each decoded bit is XORed with a keystream bit supplied from outside, and the block asks the keystream source to step once per bit. The frame ends at the first code violation, which is an over-long wait or a spacing that is too short.

A frame whose bit count lies inside the configured bounds is offered on a valid/ready output, together with its length and the tick stamp of its end. Any other outcome gives a one-cycle error strobe. A search that runs out of time gives the same strobe. The frame word and length keep their values until the next accepted start clears them.

Back-pressure rules: `frame_valid` rises once per good frame. It stays high, with `frame_data`, `frame_len` and `eof_stamp` stable, until a cycle in which `frame_ready` is high; it falls after that cycle. While `frame_valid` is high, a start request is dropped, so no new frame can overwrite one that has not been taken. The keystream source must present the bit for the next step on `ks_bit` and advance on every cycle in which `ks_step` is high.

Top module: `pp_frame_demod`

## Requirements
- R1: After reset, `frame_valid`, `frame_err` and `ks_step` are 0, and `frame_data`, `frame_len` and `eof_stamp` are 0.
- R2: `start` is taken only when the block is idle and `frame_valid` is 0. A taken start clears the frame word and the length to 0. Any other start has no effect: no `ks_step` follows it.
- R3: A taken start gives one `ks_step` at once. While searching with the line high, every TAG_PERIOD ticks gives one more `ks_step`, up to SEARCH_LIMIT of them. The next expiry after that gives `frame_err` instead, with no step.
- R4: A bit's spacing is the tick count from the previous pause start to this pause start. A spacing strictly greater than (T_ZERO+T_ONE)/2 decodes as 1, and any other spacing decodes as 0. With the defaults, 26 decodes as 0 and 27 decodes as 1.
- R5: A spacing below T_PAUSE is a code violation. It ends the frame, and no bit is added.
- R6: A code violation also occurs when the line has not returned high, or has not fallen again, more than T_ONE*3/2 ticks after the last pause start.
- R7: Bit n of a frame, counted from 0, is stored at `frame_data[n]` as decoded value XOR `ks_bit`. `frame_len` counts the bits received, and one `ks_step` follows each stored bit.
- R8: At a code violation, a length in the range MIN_LEN to MAX_LEN inclusive raises `frame_valid`. Any other length gives a one-cycle `frame_err` pulse.
- R9: `eof_stamp` is the tick stamp of the last pause start, plus T_PAUSE, minus 2.
- R10: While `frame_valid` is 1 and `frame_ready` is 0, `frame_valid`, `frame_data` and `frame_len` hold their values. A cycle with `frame_ready` high clears `frame_valid`.
- R11: `line_in` passes through a two-flop synchronizer. A level applied at one clock edge is acted on at the second edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a frame search |
| line_in | input | 1 | Demodulated field: 1 carrier, 0 pause |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Keystream advance strobe |
| frame_valid | output | 1 | Good frame available |
| frame_ready | input | 1 | Consumer takes the frame |
| frame_data | output | DATA_W | Received bits, first bit in bit 0 |
| frame_len | output | LEN_W | Number of bits received |
| eof_stamp | output | CNT_W | Tick stamp of the frame end |
| frame_err | output | 1 | One-cycle strobe for a failed frame or search |

## Verification
A wrong decoder state shows at the ports within one bit period. It can appear as a `ks_step` in the wrong cycle, a wrong bit in `frame_data`, or a `frame_len` that disagrees one cycle after the pause that should have closed a bit. A broken timeout or threshold shows as a frame that ends early or late, which moves `frame_valid`, `frame_err` and `eof_stamp` by whole cycles. The bench therefore compares every output on every cycle against a behavioural reference. It also checks threshold spacings on both sides of the midpoint, search exhaustion and held frames separately.

// File: rtl/pp_demod_pkg.sv
package pp_demod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_WAIT_LO = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pp_line_sync.sv
module pp_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_LVL;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_LVL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pp_tick_counter.sv
module pp_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/pp_interval_judge.sv
module pp_interval_judge #(
  parameter int W       = 16,
  parameter int T_ZERO  = 20,
  parameter int T_ONE   = 32,
  parameter int T_PAUSE = 8
) (
  input  logic [W-1:0] now,
  input  logic [W-1:0] ref_t,
  output logic         late,
  output logic         too_short,
  output logic         is_one
);
  localparam logic [W-1:0] MID_T = W'((T_ZERO + T_ONE) / 2);
  localparam logic [W-1:0] TMO_T = W'((T_ONE * 3) / 2);
  localparam logic [W-1:0] MIN_T = W'(T_PAUSE);

  logic [W-1:0] elapsed;

  always_comb begin
    elapsed   = now - ref_t;
    late      = elapsed > TMO_T;
    too_short = elapsed < MIN_T;
    is_one    = elapsed > MID_T;
  end
endmodule

// File: rtl/pp_frame_acc.sv
module pp_frame_acc #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data,
  output logic [LEN_W-1:0]  len
);
  localparam int              IDX_W   = $clog2(DATA_W);
  localparam logic [LEN_W-1:0] LEN_TOP = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] CAP     = LEN_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      len  <= '0;
    end else if (clear) begin
      data <= '0;
      len  <= '0;
    end else if (push) begin
      if (len < CAP) data[len[IDX_W-1:0]] <= bit_in;
      if (len != LEN_TOP) len <= len + 1'b1;
    end
  end

  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && len != LEN_TOP) |=> len == $past(len) + 1'b1);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (len == '0 && data == '0));
endmodule

// File: rtl/pp_frame_demod.sv
module pp_frame_demod
  import pp_demod_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int LEN_W        = 6,
  parameter int CNT_W        = 16,
  parameter int T_ZERO       = 20,
  parameter int T_ONE        = 32,
  parameter int T_PAUSE      = 8,
  parameter int TAG_PERIOD   = 16,
  parameter int SEARCH_LIMIT = 6,
  parameter int MIN_LEN      = 4,
  parameter int MAX_LEN      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              line_in,
  input  logic              ks_bit,
  output logic              ks_step,
  output logic              frame_valid,
  input  logic              frame_ready,
  output logic [DATA_W-1:0] frame_data,
  output logic [LEN_W-1:0]  frame_len,
  output logic [CNT_W-1:0]  eof_stamp,
  output logic              frame_err
);
  localparam int               SRCH_W  = $clog2(SEARCH_LIMIT + 1);
  localparam logic [SRCH_W-1:0] SRCH_MAX = SRCH_W'(SEARCH_LIMIT);
  localparam logic [CNT_W-1:0]  TAG_T   = CNT_W'(TAG_PERIOD);
  localparam logic [CNT_W-1:0]  EOF_ADJ = CNT_W'(T_PAUSE - 2);
  localparam logic [LEN_W-1:0]  LEN_LO  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0]  LEN_HI  = LEN_W'(MAX_LEN);

  rx_state_e         state;
  logic              s_line;
  logic [CNT_W-1:0]  now;
  logic [CNT_W-1:0]  srch_ref;
  logic [CNT_W-1:0]  bit_ref;
  logic [SRCH_W-1:0] empty_cnt;
  logic              late, too_short, is_one;
  logic              take_start, acc_push, violation, len_ok, srch_expired;

  pp_line_sync #(.STAGES(2), .RST_LVL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_in), .dout(s_line)
  );

  pp_tick_counter #(.W(CNT_W)) u_ticks (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  pp_interval_judge #(
    .W(CNT_W), .T_ZERO(T_ZERO), .T_ONE(T_ONE), .T_PAUSE(T_PAUSE)
  ) u_judge (
    .now(now), .ref_t(bit_ref),
    .late(late), .too_short(too_short), .is_one(is_one)
  );

  pp_frame_acc #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .clear(take_start), .push(acc_push), .bit_in(is_one ^ ks_bit),
    .data(frame_data), .len(frame_len)
  );

  always_comb begin
    take_start   = (state == ST_IDLE) && start && !frame_valid;
    acc_push     = (state == ST_WAIT_LO) && !s_line && !too_short;
    srch_expired = (now - srch_ref) >= TAG_T;
    len_ok       = (frame_len >= LEN_LO) && (frame_len <= LEN_HI);
    violation    = 1'b0;
    case (state)
      ST_WAIT_HI: violation = !s_line && late;
      ST_WAIT_LO: violation = s_line ? late : too_short;
      default:    violation = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      srch_ref    <= '0;
      bit_ref     <= '0;
      empty_cnt   <= '0;
      ks_step     <= 1'b0;
      frame_err   <= 1'b0;
      frame_valid <= 1'b0;
      eof_stamp   <= '0;
    end else begin
      ks_step   <= 1'b0;
      frame_err <= 1'b0;
      if (frame_valid && frame_ready) frame_valid <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (take_start) begin
            state     <= ST_SEARCH;
            srch_ref  <= now;
            empty_cnt <= '0;
            ks_step   <= 1'b1;
          end
        end
        ST_SEARCH: begin
          if (!s_line) begin
            state   <= ST_WAIT_HI;
            bit_ref <= now;
          end else if (srch_expired) begin
            srch_ref <= now;
            if (empty_cnt == SRCH_MAX) begin
              frame_err <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              empty_cnt <= empty_cnt + 1'b1;
              ks_step   <= 1'b1;
            end
          end
        end
        ST_WAIT_HI: begin
          if (s_line) state <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          if (acc_push) begin
            ks_step <= 1'b1;
            bit_ref <= now;
            state   <= ST_WAIT_HI;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (violation) begin
        state <= ST_IDLE;
        if (len_ok) begin
          frame_valid <= 1'b1;
          eof_stamp   <= bit_ref + EOF_ADJ;
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_ready) |=>
      (frame_valid && $stable(frame_data) && $stable(frame_len)));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> (frame_len >= LEN_LO && frame_len <= LEN_HI));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !frame_valid);

  // R3
  err_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !ks_step);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_ready && start) |=> !ks_step);
endmodule

// File: tb/pp_frame_demod_bench.sv
`timescale 1ns/1ps
module pp_frame_demod_bench;
  localparam int TAG = 16, LIM = 6, PW = 8, T0 = 20, T1 = 32;
  localparam int MID = (T0 + T1) / 2, TMO = (T1 * 3) / 2;
  localparam int MINL = 4, MAXL = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, line_in = 1'b1;
  logic frame_ready = 1'b1, ks_on = 1'b0;
  logic ks_step, frame_valid, frame_err, ks_bit;
  logic [31:0] frame_data;
  logic [5:0]  frame_len;
  logic [15:0] eof_stamp;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0, errors = 0, cycles = 0, ks_cnt = 0, err_cnt = 0, got_cnt = 0;
  logic [31:0] got_data;
  logic [5:0]  got_len;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  pp_frame_demod u_pp_frame_demod (
    .clk(clk), .rst_n(rst_n), .start(start), .line_in(line_in),
    .ks_bit(ks_bit), .ks_step(ks_step), .frame_valid(frame_valid),
    .frame_ready(frame_ready), .frame_data(frame_data), .frame_len(frame_len),
    .eof_stamp(eof_stamp), .frame_err(frame_err)
  );

  assign ks_bit = ks_on & lfsr[0];
  always @(posedge clk) if (ks_step) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  // behavioural reference, evaluated at each rising edge
  int   m_state, m_now, m_sref, m_bref, m_empty, m_len, m_eof, m_el;
  logic [31:0] m_data;
  logic m_valid, m_err, m_ks, m_q0, m_q1, m_s, m_vold, m_viol, m_bit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_now = 0; m_sref = 0; m_bref = 0; m_empty = 0; m_len = 0;
      m_eof = 0; m_data = 0; m_valid = 0; m_err = 0; m_ks = 0; m_q0 = 1; m_q1 = 1;
    end else begin
      m_s = m_q1; m_q1 = m_q0; m_q0 = line_in;
      m_ks = 0; m_err = 0; m_viol = 0; m_vold = m_valid;
      if (m_valid && frame_ready) m_valid = 0;
      m_el = m_now - ((m_state == 1) ? m_sref : m_bref);
      case (m_state)
        0: if (start && !m_vold) begin
             m_state = 1; m_sref = m_now; m_empty = 0; m_ks = 1; m_len = 0; m_data = 0;
           end
        1: if (!m_s) begin m_state = 2; m_bref = m_now; end
           else if (m_el >= TAG) begin
             m_sref = m_now;
             if (m_empty == LIM) begin m_err = 1; m_state = 0; end
             else begin m_empty++; m_ks = 1; end
           end
        2: if (m_s) m_state = 3; else if (m_el > TMO) m_viol = 1;
        3: if (!m_s) begin
             if (m_el < PW) m_viol = 1;
             else begin
               m_bit = (m_el > MID) ^ ks_bit;
               if (m_len < 32) m_data[m_len] = m_bit;
               if (m_len < 63) m_len++;
               m_ks = 1; m_bref = m_now; m_state = 2;
             end
           end else if (m_el > TMO) m_viol = 1;
        default: m_state = 0;
      endcase
      if (m_viol) begin
        m_state = 0;
        if (m_len < MINL || m_len > MAXL) m_err = 1;
        else begin m_valid = 1; m_eof = m_bref + PW - 2; end
      end
      m_now++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // per-cycle comparison and monitors, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(frame_valid === m_valid, "R10 frame_valid", 32'(frame_valid), 32'(m_valid));
      check(frame_err === m_err, "R8 frame_err", 32'(frame_err), 32'(m_err));
      check(ks_step === m_ks, "R3 ks_step", 32'(ks_step), 32'(m_ks));
      check(frame_len === 6'(m_len), "R7 frame_len", 32'(frame_len), 32'(m_len));
      check(frame_data === m_data, "R7 frame_data", frame_data, m_data);
      check(eof_stamp === 16'(m_eof), "R9 eof_stamp", 32'(eof_stamp), 32'(m_eof & 16'hFFFF));
      if (ks_step) ks_cnt++;
      if (frame_err) err_cnt++;
      if (frame_valid && frame_ready) begin got_cnt++; got_data = frame_data; got_len = frame_len; end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  // tail: 0 = line stays high, 1 = a too-short spacing, 2 = pause held low
  task automatic send_frame(input int n, input logic [31:0] bits, input int p0, input int p1, input int tail);
    pulse_start();
    idle(5);
    for (int i = 0; i < n; i++) begin
      line_in = 1'b0; idle(4);
      line_in = 1'b1; idle((bits[i] ? p1 : p0) - 4);
    end
    if (tail == 1) begin
      line_in = 1'b0; idle(4); line_in = 1'b1; idle(2);
    end
    line_in = 1'b0;
    idle(tail == 2 ? 60 : 4);
    line_in = 1'b1;
    idle(70);
  endtask

  initial begin
    int c0, e0, k0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(frame_valid == 0 && frame_err == 0 && ks_step == 0, "R1 strobes", {frame_valid, frame_err, ks_step}, 0);
    check(frame_data == 0 && frame_len == 0 && eof_stamp == 0, "R1 data", frame_data | 32'(frame_len), 0);

    // R4 R7 R8: plain frame, keystream held at 0
    c0 = got_cnt;
    send_frame(8, 32'hA5, T0, T1, 0);
    check(got_cnt == c0 + 1, "R8 good frame", got_cnt, c0 + 1);
    check(got_data == 32'hA5, "R7 data lsb first", got_data, 32'hA5);
    check(got_len == 8, "R7 length", 32'(got_len), 8);

    // R4: spacing 26 reads 0, 27 reads 1
    send_frame(6, 32'h2C, 26, 27, 0);
    check(got_data == 32'h2C, "R4 threshold", got_data, 32'h2C);

    // R7: keystream applied
    ks_on = 1'b1;
    send_frame(12, 32'h9F3, T0, T1, 0);
    check(got_len == 12, "R7 keyed length", 32'(got_len), 12);
    ks_on = 1'b0;

    // R5: too-short spacing ends a 5 bit frame
    send_frame(5, 32'h15, T0, T1, 1);
    check(got_len == 5 && got_data == 32'h15, "R5 short spacing", {26'd0, got_len}, 5);

    // R6: pause held past the timeout
    send_frame(7, 32'h4B, T0, T1, 2);
    check(got_len == 7 && got_data == 32'h4B, "R6 pulse wait timeout", {26'd0, got_len}, 7);

    // R8: too few and too many bits
    e0 = err_cnt;
    send_frame(2, 32'h3, T0, T1, 0);
    check(err_cnt == e0 + 1, "R8 short frame error", err_cnt, e0 + 1);
    e0 = err_cnt; c0 = got_cnt;
    send_frame(26, 32'h2AB_CDEF, T0, T1, 0);
    check(err_cnt == e0 + 1 && got_cnt == c0, "R8 long frame error", err_cnt, e0 + 1);

    // R3: empty search
    k0 = ks_cnt; e0 = err_cnt;
    pulse_start();
    idle((LIM + 2) * TAG + 20);
    check(ks_cnt - k0 == LIM + 1, "R3 search steps", ks_cnt - k0, LIM + 1);
    check(err_cnt == e0 + 1, "R3 search error", err_cnt, e0 + 1);

    // R10 R2: held frame, start dropped
    frame_ready = 1'b0;
    c0 = got_cnt;
    send_frame(9, 32'h1C7, T0, T1, 0);
    check(frame_valid == 1, "R10 valid held", 32'(frame_valid), 1);
    k0 = ks_cnt;
    pulse_start();
    idle(10);
    check(ks_cnt == k0, "R2 start ignored", ks_cnt, k0);
    check(frame_data == 32'h1C7 && frame_len == 9, "R10 data held", frame_data, 32'h1C7);
    frame_ready = 1'b1;
    idle(2);
    check(frame_valid == 0 && got_cnt == c0 + 1, "R10 release", 32'(frame_valid), 0);

    // R11: timing of whole frames is covered by the per-cycle reference
    send_frame(10, 32'h2D3, T0, T1, 0);
    check(got_len == 10, "R11 sync frame", 32'(got_len), 10);

    idle(5);
    finish_run();
  end
endmodule